// File: doc/BRIEF.md
# Parallel Flash Write Sequencer

This block sits on the host side of a byte-wide parallel flash bus and turns one request into a full write operation on the device. A request carries an operation code, a target address and a data byte. It is accepted on a valid/ready handshake. The block then sends the unlock and command write cycles that the operation needs. After that it polls the target location until the device stops reporting busy, and it reads the location back to confirm that the result is correct.

Busy is detected with the toggle method. Bit 6 of consecutive status reads flips while the device is working and holds steady once the device is finished. After the toggling stops, one confirming read is compared with the expected value: the programmed byte for a program, or all ones for an erase. The device may finish at the same moment a status read is sampled. To keep that race from producing a false failure, a mismatching confirmation is followed by two more reads, and the request passes only if both of them match. A read counter stops the poll if the device never settles. The block then reports a timeout.

Every bus cycle holds its strobes low for a parameterised number of clocks. The address is held steady for the whole cycle, and on writes the data is held as well. Each strobe period is followed by one recovery clock with all strobes high.

Top module: `flash_wr_ctrl`

## Requirements
- R1: While reset is held and after it is released, `req_ready` is 1, `done` is 0, and `fl_ce_n`, `fl_we_n` and `fl_oe_n` are all 1.
- R2: Operation code 0 (program) issues exactly four write cycles, as address/data pairs in this order: 555h/AAh, 2AAh/55h, 555h/A0h, then the target address with the request data.
- R3: Operation code 1 (sector erase) issues exactly six write cycles in this order: 555h/AAh, 2AAh/55h, 555h/80h, 555h/AAh, 2AAh/55h, then the target address with data 20h.
- R4: Operation codes 2 and 3 (chip erase) issue the same first five writes as R3, and then a last write of 10h to address 555h.
- R5: In every bus cycle, `fl_ce_n` is low for exactly STRB_CYC clocks. A write cycle has `fl_we_n` low, `fl_oe_n` high and `fl_dq_oe` high. A read cycle has `fl_oe_n` low and `fl_we_n` high. The address does not change while `fl_ce_n` is low.
- R6: No read cycle starts before the last command write of the request has completed.
- R7: All reads go to the target address. The poll ends when bit 6 is equal in two consecutive reads. Exactly one confirming read follows. If it matches the expected value (the request data for a program, FFh for an erase), `ok` is 1.
- R8: If the confirming read mismatches, exactly two more reads follow. `ok` is 1 only if both of them equal the expected value.
- R9: If bit 6 still differs between consecutive reads after POLL_MAX comparisons (POLL_MAX+1 status reads in total), the request ends with `timed_out`=1 and `ok`=0, and no confirming read is made.
- R10: `req_ready` falls in the cycle after a request is accepted and stays low until `done`. Requests presented while it is low cause no bus cycles.
- R11: `done` is a one-clock pulse. In that same clock `ok` and `timed_out` give the result of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_op | input | 2 | 0 program, 1 sector erase, 2 or 3 chip erase |
| req_addr | input | AW | Target address (also the polled location) |
| req_data | input | 8 | Byte to program |
| done | output | 1 | One-clock completion pulse |
| ok | output | 1 | Request confirmed correct |
| timed_out | output | 1 | Poll limit reached |
| fl_a | output | AW | Flash address |
| fl_dq_o | output | 8 | Flash data out |
| fl_dq_oe | output | 1 | Flash data drive enable |
| fl_dq_i | input | 8 | Flash data in |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_we_n | output | 1 | Write strobe, active low |
| fl_oe_n | output | 1 | Output enable, active low |

## Verification
Two things can land on the same read: the end of the device's internal operation and the sampling of the confirming read. A confirming read taken at that boundary can carry stale data. The bench's device model provokes this on purpose. It corrupts a chosen number of reads that follow the settled toggle pair, and it sweeps that number from zero to three against every busy length from zero up to the poll limit. For each case the bench works out the expected outcome and the exact read count from the values the model returns. One corrupted read must still pass after five reads, and two or more must fail. The busy length one past the limit must time out after exactly POLL_MAX+1 reads.

// File: rtl/fwc_pkg.sv
package fwc_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_CHIP = 2'd2
  } fwc_op_e;

  localparam logic [7:0] ERASED_BYTE = 8'hFF;

  function automatic fwc_op_e decode_op(input logic [1:0] code);
    if (code == 2'd0)      return OP_PROG;
    else if (code == 2'd1) return OP_SECT;
    else                   return OP_CHIP;
  endfunction

  function automatic logic [2:0] cmd_len(input fwc_op_e op);
    return (op == OP_PROG) ? 3'd4 : 3'd6;
  endfunction

endpackage

// File: rtl/fwc_cmdgen.sv
module fwc_cmdgen #(
  parameter int AW = 19
) (
  input  fwc_pkg::fwc_op_e op,
  input  logic [2:0]       idx,
  input  logic [AW-1:0]    tgt,
  input  logic [7:0]       dat,
  output logic [AW-1:0]    a,
  output logic [7:0]       d
);
  import fwc_pkg::*;

  localparam logic [AW-1:0] A_ODD  = AW'(12'h555);
  localparam logic [AW-1:0] A_EVEN = AW'(12'h2AA);

  always_comb begin
    a = A_ODD;
    d = 8'hAA;
    if (op == OP_PROG && idx == 3'd3) begin
      a = tgt;
      d = dat;
    end else begin
      case (idx)
        3'd1, 3'd4: begin a = A_EVEN; d = 8'h55; end
        3'd2:       begin a = A_ODD;  d = (op == OP_PROG) ? 8'hA0 : 8'h80; end
        3'd5: begin
          if (op == OP_SECT) begin a = tgt;   d = 8'h20; end
          else               begin a = A_ODD; d = 8'h10; end
        end
        default:    begin a = A_ODD;  d = 8'hAA; end
      endcase
    end
  end

endmodule

// File: rtl/fwc_bus.sv
module fwc_bus #(
  parameter int AW   = 19,
  parameter int STRB = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic          done,
  output logic [7:0]    rdata,
  output logic [AW-1:0] bus_a,
  output logic [7:0]    bus_dq_o,
  output logic          bus_dq_oe,
  input  logic [7:0]    bus_dq_i,
  output logic          bus_ce_n,
  output logic          bus_we_n,
  output logic          bus_oe_n
);
  localparam int CW = (STRB > 1) ? $clog2(STRB) : 1;

  typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_REC} ph_e;
  ph_e           ph;
  logic [CW-1:0] cnt;
  logic          is_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= PH_IDLE;
      cnt       <= '0;
      is_wr     <= 1'b0;
      done      <= 1'b0;
      rdata     <= '0;
      bus_a     <= '0;
      bus_dq_o  <= '0;
      bus_dq_oe <= 1'b0;
      bus_ce_n  <= 1'b1;
      bus_we_n  <= 1'b1;
      bus_oe_n  <= 1'b1;
    end else begin
      done <= 1'b0;
      case (ph)
        PH_IDLE: if (go) begin
          ph        <= PH_LOW;
          cnt       <= CW'(STRB - 1);
          is_wr     <= wr;
          bus_a     <= addr;
          bus_dq_o  <= wdata;
          bus_dq_oe <= wr;
          bus_ce_n  <= 1'b0;
          bus_we_n  <= !wr;
          bus_oe_n  <= wr;
        end
        PH_LOW: begin
          if (cnt == '0) begin
            ph       <= PH_REC;
            bus_ce_n <= 1'b1;
            bus_we_n <= 1'b1;
            bus_oe_n <= 1'b1;
            if (!is_wr) rdata <= bus_dq_i;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_REC: begin
          ph        <= PH_IDLE;
          bus_dq_oe <= 1'b0;
          done      <= 1'b1;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // R5: a new cycle is only requested while the engine is free
  p_go_when_free_r5: assert property (@(posedge clk) disable iff (rst)
    go |-> (ph == PH_IDLE));
  // R5: address steady while chip enable is low
  p_addr_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!bus_ce_n && $past(!bus_ce_n)) |-> $stable(bus_a));
  // R5: write strobe only with data driven and output enable off
  p_write_drive_r5: assert property (@(posedge clk) disable iff (rst)
    !bus_we_n |-> (bus_dq_oe && bus_oe_n && !bus_ce_n));

endmodule

// File: rtl/fwc_tmo.sv
module fwc_tmo #(
  parameter int LIMIT = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic step,
  output logic hit
);
  localparam int TW = $clog2(LIMIT + 1);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)        cnt <= '0;
    else if (step && !hit) cnt <= cnt + 1'b1;
  end

  assign hit = (cnt == TW'(LIMIT - 1));

  // R9: the comparison count never passes the limit
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (rst)
    cnt < TW'(LIMIT));

endmodule

// File: rtl/flash_wr_ctrl.sv
module flash_wr_ctrl #(
  parameter int AW       = 19,
  parameter int STRB_CYC = 3,
  parameter int POLL_MAX = 4096
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_data,
  output logic          done,
  output logic          ok,
  output logic          timed_out,
  output logic [AW-1:0] fl_a,
  output logic [7:0]    fl_dq_o,
  output logic          fl_dq_oe,
  input  logic [7:0]    fl_dq_i,
  output logic          fl_ce_n,
  output logic          fl_we_n,
  output logic          fl_oe_n
);
  import fwc_pkg::*;

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_ST1, S_ST2, S_VER, S_RR1, S_RR2} st_e;

  st_e           st;
  fwc_op_e       op_q;
  logic [AW-1:0] tgt_q;
  logic [7:0]    dat_q;
  logic [2:0]    idx;
  logic          pend, prev6, rok1;
  logic          go, go_wr;
  logic [AW-1:0] go_a;
  logic [7:0]    go_d;
  logic          bus_done;
  logic [7:0]    bus_rdata;
  logic [AW-1:0] cg_a;
  logic [7:0]    cg_d;
  logic          tmo_hit;
  logic [7:0]    exp_val;
  logic          toggling;

  assign exp_val  = (op_q == OP_PROG) ? dat_q : ERASED_BYTE;
  assign toggling = (bus_rdata[6] != prev6);

  fwc_cmdgen #(.AW(AW)) u_cmd (
    .op(op_q), .idx(idx), .tgt(tgt_q), .dat(dat_q), .a(cg_a), .d(cg_d));

  fwc_bus #(.AW(AW), .STRB(STRB_CYC)) u_bus (
    .clk(clk), .rst(rst), .go(go), .wr(go_wr), .addr(go_a), .wdata(go_d),
    .done(bus_done), .rdata(bus_rdata), .bus_a(fl_a), .bus_dq_o(fl_dq_o),
    .bus_dq_oe(fl_dq_oe), .bus_dq_i(fl_dq_i), .bus_ce_n(fl_ce_n),
    .bus_we_n(fl_we_n), .bus_oe_n(fl_oe_n));

  fwc_tmo #(.LIMIT(POLL_MAX)) u_tmo (
    .clk(clk), .rst(rst), .clr(st == S_ST1),
    .step((st == S_ST2) && bus_done && toggling), .hit(tmo_hit));

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      op_q      <= OP_PROG;
      tgt_q     <= '0;
      dat_q     <= '0;
      idx       <= '0;
      pend      <= 1'b0;
      prev6     <= 1'b0;
      rok1      <= 1'b0;
      go        <= 1'b0;
      go_wr     <= 1'b0;
      go_a      <= '0;
      go_d      <= '0;
      req_ready <= 1'b1;
      done      <= 1'b0;
      ok        <= 1'b0;
      timed_out <= 1'b0;
    end else begin
      go   <= 1'b0;
      done <= 1'b0;
      case (st)
        S_IDLE: if (req_valid && req_ready) begin
          op_q      <= decode_op(req_op);
          tgt_q     <= req_addr;
          dat_q     <= req_data;
          idx       <= '0;
          pend      <= 1'b1;
          req_ready <= 1'b0;
          st        <= S_CMD;
        end
        S_CMD: begin
          if (pend) begin
            pend <= 1'b0; go <= 1'b1; go_wr <= 1'b1; go_a <= cg_a; go_d <= cg_d;
          end else if (bus_done) begin
            if (idx == cmd_len(op_q) - 3'd1) begin
              go <= 1'b1; go_wr <= 1'b0; go_a <= tgt_q;
              st <= S_ST1;
            end else begin
              idx  <= idx + 3'd1;
              pend <= 1'b1;
            end
          end
        end
        S_ST1: if (bus_done) begin
          prev6 <= bus_rdata[6];
          go <= 1'b1; go_wr <= 1'b0; go_a <= tgt_q;
          st <= S_ST2;
        end
        S_ST2: if (bus_done) begin
          if (!toggling) begin
            go <= 1'b1; go_wr <= 1'b0; go_a <= tgt_q;
            st <= S_VER;
          end else if (tmo_hit) begin
            done <= 1'b1; ok <= 1'b0; timed_out <= 1'b1;
            req_ready <= 1'b1; st <= S_IDLE;
          end else begin
            prev6 <= bus_rdata[6];
            go <= 1'b1; go_wr <= 1'b0; go_a <= tgt_q;
          end
        end
        S_VER: if (bus_done) begin
          if (bus_rdata == exp_val) begin
            done <= 1'b1; ok <= 1'b1; timed_out <= 1'b0;
            req_ready <= 1'b1; st <= S_IDLE;
          end else begin
            go <= 1'b1; go_wr <= 1'b0; go_a <= tgt_q;
            st <= S_RR1;
          end
        end
        S_RR1: if (bus_done) begin
          rok1 <= (bus_rdata == exp_val);
          go <= 1'b1; go_wr <= 1'b0; go_a <= tgt_q;
          st <= S_RR2;
        end
        S_RR2: if (bus_done) begin
          done <= 1'b1; ok <= rok1 && (bus_rdata == exp_val); timed_out <= 1'b0;
          req_ready <= 1'b1; st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R10: acceptance drops ready on the next clock
  p_accept_drops_ready_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  // R10: ready only returns together with completion
  p_ready_with_done_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(req_ready) |-> done);
  // R11: completion is a single-clock pulse
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R9: a timeout never reports success
  p_timeout_fails_r9: assert property (@(posedge clk) disable iff (rst)
    (done && timed_out) |-> !ok);
  // R6: no read strobe while command writes are still being sent
  p_no_read_in_cmd_r6: assert property (@(posedge clk) disable iff (rst)
    (st == S_CMD) |-> fl_oe_n);

endmodule

// File: tb/flash_wr_ctrl_tb.sv
module flash_wr_ctrl_tb_top;
  localparam int AW = 11;
  localparam int STRB = 2;
  localparam int PMAX = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0] req_data = '0;
  logic req_ready, done, ok, timed_out;
  logic [AW-1:0] fl_a;
  logic [7:0] fl_dq_o, fl_dq_i;
  logic fl_dq_oe, fl_ce_n, fl_we_n, fl_oe_n;

  always #10 clk = ~clk;

  flash_wr_ctrl #(.AW(AW), .STRB_CYC(STRB), .POLL_MAX(PMAX)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .done(done),
    .ok(ok), .timed_out(timed_out), .fl_a(fl_a), .fl_dq_o(fl_dq_o),
    .fl_dq_oe(fl_dq_oe), .fl_dq_i(fl_dq_i), .fl_ce_n(fl_ce_n),
    .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n));

  int n_chk = 0, n_fail = 0;
  int cyc = 0;

  task automatic chk(input bit good, input string req, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // ---------------- device model ----------------
  logic [7:0] mem [0:(1<<AW)-1];
  int mb = 0, mg = 0, kread = 0, post = 0, ucyc = 0;
  bit mbusy = 0;
  int nw = 0, nrd = 0, nw_first = -1, bad_raddr = 0, pw_bad = 0, lowcnt = 0;
  logic [AW-1:0] wa [0:15];
  logic [7:0] wd [0:15];
  logic [AW-1:0] lat_a = '0, exp_raddr = '0;
  logic [7:0] lat_d = '0;
  logic pwe = 1'b1, poe = 1'b1, pce = 1'b1;

  initial fl_dq_i = 8'h00;

  task automatic start_busy();
    mbusy = (mb > 0);
    kread = 0;
    post = 0;
  endtask

  task automatic m_write(input logic [AW-1:0] a, input logic [7:0] d);
    if (nw < 16) begin wa[nw] = a; wd[nw] = d; end
    nw++;
    if (mbusy) return;
    case (ucyc)
      0: ucyc = (a == 11'h555 && d == 8'hAA) ? 1 : 0;
      1: ucyc = (a == 11'h2AA && d == 8'h55) ? 2 : 0;
      2: if (a == 11'h555 && d == 8'hA0) ucyc = 3;
         else if (a == 11'h555 && d == 8'h80) ucyc = 4;
         else ucyc = 0;
      3: begin mem[a] = mem[a] & d; start_busy(); ucyc = 0; end
      4: ucyc = (a == 11'h555 && d == 8'hAA) ? 5 : 0;
      5: ucyc = (a == 11'h2AA && d == 8'h55) ? 6 : 0;
      6: begin
        if (d == 8'h20) begin
          for (int i = 0; i < 128; i++) mem[{a[AW-1:7], 7'd0} + AW'(i)] = 8'hFF;
          start_busy();
        end else if (a == 11'h555 && d == 8'h10) begin
          for (int i = 0; i < (1<<AW); i++) mem[i] = 8'hFF;
          start_busy();
        end
        ucyc = 0;
      end
      default: ucyc = 0;
    endcase
  endtask

  task automatic m_read();
    logic [7:0] v;
    nrd++;
    if (nrd == 1) nw_first = nw;
    if (fl_a != exp_raddr) bad_raddr++;
    v = mem[fl_a];
    if (mbusy) begin
      kread++;
      v = {~v[7], ~v[6] ^ (((mb - kread) % 2) != 0), v[5:0]};
      if (kread >= mb) mbusy = 0;
    end else begin
      post++;
      if (post >= 3 && post < 3 + mg) v = v ^ 8'h01;
    end
    fl_dq_i = v;
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (!fl_ce_n) lowcnt++;
      if (!fl_we_n) begin
        lat_a = fl_a; lat_d = fl_dq_o;
        if (!fl_dq_oe || !fl_oe_n) pw_bad++;
      end
      if (!fl_oe_n && !fl_we_n) pw_bad++;
      if (fl_ce_n && !pce) begin
        if (lowcnt != STRB) pw_bad++;
        lowcnt = 0;
      end
      if (fl_we_n && !pwe) m_write(lat_a, lat_d);
      if (!fl_oe_n && poe) m_read();
      pwe = fl_we_n; poe = fl_oe_n; pce = fl_ce_n;
    end
  end

  // ---------------- expectations ----------------
  function automatic logic [AW-1:0] ew_a(input int op, input int i, input logic [AW-1:0] t);
    if (i == 1 || i == 4) return 11'h2AA;
    if (op == 0 && i == 3) return t;
    if (i == 5 && op == 1) return t;
    return 11'h555;
  endfunction

  function automatic logic [7:0] ew_d(input int op, input int i, input logic [7:0] d);
    if (i == 1 || i == 4) return 8'h55;
    if (i == 2) return (op == 0) ? 8'hA0 : 8'h80;
    if (op == 0 && i == 3) return d;
    if (i == 5) return (op == 1) ? 8'h20 : 8'h10;
    return 8'hAA;
  endfunction

  task automatic do_op(input int op, input logic [AW-1:0] a, input logic [7:0] d,
                       input int b, input int g, input bit spur);
    int opk, nwx, nrx, k;
    bit ok_x, tmo_x, seen;
    logic [7:0] v, ex, r1, r2, r3;
    string rq;
    opk = (op >= 2) ? 2 : op;
    nwx = (opk == 0) ? 4 : 6;
    ex  = (opk == 0) ? d : 8'hFF;
    v   = (opk == 0) ? (mem[a] & d) : 8'hFF;
    r1 = (g >= 1) ? v ^ 8'h01 : v;
    r2 = (g >= 2) ? v ^ 8'h01 : v;
    r3 = (g >= 3) ? v ^ 8'h01 : v;
    if (b >= PMAX) begin
      tmo_x = 1; ok_x = 0; nrx = PMAX + 1;
    end else begin
      tmo_x = 0;
      if (r1 == ex) begin ok_x = 1; nrx = b + 3; end
      else begin ok_x = (r2 == ex) && (r3 == ex); nrx = b + 5; end
    end
    rq = (opk == 0) ? "R2" : (opk == 1) ? "R3" : "R4";
    @(negedge clk);
    nw = 0; nrd = 0; nw_first = -1; bad_raddr = 0; pw_bad = 0;
    mb = b; mg = g; exp_raddr = a;
    chk(req_ready == 1'b1, "R10", "ready before request", req_ready, 1);
    req_valid = 1'b1; req_op = 2'(op); req_addr = a; req_data = d;
    @(negedge clk);
    chk(req_ready == 1'b0, "R10", "ready after accept", req_ready, 0);
    if (spur) begin req_op = 2'd2; req_addr = '0; req_data = 8'h00; end
    else req_valid = 1'b0;
    seen = 0;
    k = 0;
    while (!seen && k < 3000) begin
      if (done) seen = 1;
      else begin @(negedge clk); k++; end
    end
    req_valid = 1'b0;
    chk(seen, "R11", "done seen", seen, 1);
    chk(ok == ok_x, "R11", "ok", ok, ok_x);
    chk(timed_out == tmo_x, "R9", "timed_out", timed_out, tmo_x);
    chk(nw == nwx, rq, "write count (R10 when spurious)", nw, nwx);
    for (int i = 0; i < nwx && i < nw; i++) begin
      chk(wa[i] == ew_a(opk, i, a), rq, "write address", wa[i], ew_a(opk, i, a));
      chk(wd[i] == ew_d(opk, i, d), rq, "write data", wd[i], ew_d(opk, i, d));
    end
    chk(nw_first == nwx, "R6", "writes before first read", nw_first, nwx);
    chk(nrd == nrx, tmo_x ? "R9" : (nrx > b + 3 ? "R8" : "R7"), "read count", nrd, nrx);
    chk(bad_raddr == 0, "R7", "reads off target", bad_raddr, 0);
    chk(pw_bad == 0, "R5", "strobe violations", pw_bad, 0);
    @(negedge clk);
    chk(done == 1'b0, "R11", "done one clock", done, 0);
    chk(nw == nwx, "R10", "no write after done", nw, nwx);
    if (mbusy) mbusy = 0;
  endtask

  initial begin
    for (int i = 0; i < (1<<AW); i++) mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    chk(req_ready && !done && fl_ce_n && fl_we_n && fl_oe_n, "R1", "outputs in reset",
        {req_ready, done, fl_ce_n, fl_we_n, fl_oe_n}, 5'b10111);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(req_ready && !done && fl_ce_n && fl_we_n && fl_oe_n, "R1", "outputs after reset",
        {req_ready, done, fl_ce_n, fl_we_n, fl_oe_n}, 5'b10111);
    // R7 R8: busy length and boundary-race sweep on program requests
    for (int b = 0; b < PMAX; b++)
      for (int g = 0; g < 4; g++)
        do_op(0, AW'(11'h100 + b * 4 + g), 8'h5A ^ 8'(b * 16 + g), b, g, 0);
    // R8: programming a one over a zero cannot be confirmed
    do_op(0, 11'h101, 8'hFF, 2, 0, 0);
    // R3 with R10: sector erase while a second request is held valid
    do_op(1, 11'h110, 8'h00, 3, 1, 1);
    // R2: erased location programs again
    do_op(0, 11'h101, 8'h3C, 1, 0, 0);
    // R4: both chip-erase codes
    do_op(2, 11'h7FF, 8'h00, 5, 0, 0);
    do_op(3, 11'h033, 8'h00, 0, 2, 0);
    // R9: poll limit boundary and a device that stays busy
    do_op(0, 11'h200, 8'h11, PMAX, 0, 0);
    do_op(1, 11'h280, 8'h00, PMAX + 5, 0, 0);
    do_op(0, 11'h201, 8'h22, PMAX - 1, 0, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule